// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous SRAM

This block is a single-port synchronous static memory with a parameterised number of 32-bit words. Each word is split into four 8-bit lanes. A burst sequencer in front of it supplies a word address and a select strobe on every clock. The rising edge that samples a command also commits any write to the array in that same edge. The same edge loads read data into an output register, so a read word appears one clock later. A global write strobe takes priority over the per-lane write controls.

The data outputs are gated by an asynchronous output enable and by a drive-enable flag that tells the pad logic when to drive. Deselecting the block or issuing a write turns the drive off after the next edge. A sleep input turns the drive off at once, makes the block ignore all commands and keeps the stored words. When sleep is released, a fixed number of recovery clocks follows, and the block stays idle until a new command arrives.

Every clock accepts a command, so there is no back-pressure. The sequencer is expected to hold `sel` low on cycles with no work.

Top module: `sync_bw_sram`

## Requirements
- R1: With `sel` high at an edge and `glob_wr_n` low, all four lanes of the addressed word take `wdata`, whatever the values of `wr_en_n` and `byte_sel_n`.
- R2: With `sel` high, `glob_wr_n` high and `wr_en_n` low, each lane k whose `byte_sel_n[k]` is low is written from `wdata[8k+7:8k]`. The other lanes keep their contents.
- R3: With `glob_wr_n` high, `wr_en_n` low and all of `byte_sel_n` high, the cycle is a write that changes no lane.
- R4: With `sel` high and both `glob_wr_n` and `wr_en_n` high, the cycle is a read. After that edge `drive_en` is high while `oe_n` is low, and `rdata` holds the addressed word.
- R5: A read in the cycle right after a write to the same address returns the newly written data.
- R6: `oe_n` acts without a clock. While it is high, `drive_en` is low. Whenever `drive_en` is low, `rdata` is all zeros.
- R7: After an edge that accepts a write, `drive_en` is low even with `oe_n` low.
- R8: After an edge with `sel` low, `drive_en` is low.
- R9: A high on `sleep` drops `drive_en` at once without a clock. Commands issued while asleep are ignored, and stored words are kept.
- R10: After `sleep` falls, the first WAKE_CYCLES edges ignore all commands. `drive_en` then stays low until a read is accepted.
- R11: During and right after reset, `drive_en` is low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Command strobe from the sequencer |
| addr | input | ADDR_W | Word address |
| glob_wr_n | input | 1 | Active-low write of all lanes |
| wr_en_n | input | 1 | Active-low lane-write enable |
| byte_sel_n | input | 4 | Active-low per-lane select; bit k is bits 8k+7:8k |
| wdata | input | 32 | Write data |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous sleep request |
| rdata | output | 32 | Registered read data, zero when not driven |
| drive_en | output | 1 | High when the pads should drive `rdata` |

## Verification
The bench builds the block with ADDR_W = 4 and WAKE_CYCLES = 3. The 16-word array is small enough to fill completely with global writes before the vector table runs, so every later read has a known expected word. A recovery window of three clocks lets the bench send a write on each recovery edge and then show that none of them reached the array. These values also leave enough room to test lane masks, back-to-back write and read on one address, deselect, and output-enable changes in the middle of a cycle.

// File: rtl/sync_bw_sram_pkg.sv
package sync_bw_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_t;
endpackage

// File: rtl/bw_decode.sv
module bw_decode
  import sync_bw_sram_pkg::*;
#(
  parameter int N_LANES = LANES
) (
  input  logic               access_ok,
  input  logic               glob_wr_n,
  input  logic               wr_en_n,
  input  logic [N_LANES-1:0] byte_sel_n,
  output acc_t               kind,
  output logic [N_LANES-1:0] lane_we
);
  // global write wins over the lane controls
  always_comb begin
    if (!access_ok)                  kind = ACC_NONE;
    else if (!glob_wr_n || !wr_en_n) kind = ACC_WRITE;
    else                             kind = ACC_READ;
  end

  always_comb begin
    lane_we = '0;
    if (kind == ACC_WRITE) lane_we = glob_wr_n ? ~byte_sel_n : '1;
  end
endmodule

// File: rtl/wake_gate.sv
module wake_gate #(
  parameter int WAKE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  output logic ready
);
  localparam int CW = (WAKE_CYCLES > 0) ? $clog2(WAKE_CYCLES + 1) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(WAKE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (sleep)        cnt_q <= RELOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign ready = !sleep && (cnt_q == '0);
endmodule

// File: rtl/lane_array.sv
module lane_array
  import sync_bw_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int N_LANES = LANES,
  parameter int L_W     = LANE_W
) (
  input  logic                   clk,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [N_LANES-1:0]     lane_we,
  input  logic                   rd_en,
  input  logic [N_LANES*L_W-1:0] wdata,
  output logic [N_LANES*L_W-1:0] rword_q
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic [L_W-1:0] store [DEPTH];
    logic [L_W-1:0] q;

    always_ff @(posedge clk) begin
      if (lane_we[g]) store[addr] <= wdata[g*L_W +: L_W];
      if (rd_en)      q <= store[addr];
    end

    assign rword_q[g*L_W +: L_W] = q;
  end
endmodule

// File: rtl/sync_bw_sram.sv
module sync_bw_sram
  import sync_bw_sram_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int WAKE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              glob_wr_n,
  input  logic              wr_en_n,
  input  logic [3:0]        byte_sel_n,
  input  logic [31:0]       wdata,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [31:0]       rdata,
  output logic              drive_en
);
  logic              wake_ok;
  acc_t              kind;
  logic [LANES-1:0]  lane_we;
  logic [WORD_W-1:0] rword_q;
  logic              rd_valid_q;

  wake_gate #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .ready(wake_ok)
  );

  bw_decode #(.N_LANES(LANES)) u_dec (
    .access_ok(sel && wake_ok), .glob_wr_n(glob_wr_n), .wr_en_n(wr_en_n),
    .byte_sel_n(byte_sel_n), .kind(kind), .lane_we(lane_we)
  );

  lane_array #(.ADDR_W(ADDR_W), .N_LANES(LANES), .L_W(LANE_W)) u_arr (
    .clk(clk), .addr(addr), .lane_we(lane_we), .rd_en(kind == ACC_READ),
    .wdata(wdata), .rword_q(rword_q)
  );

  // single-cycle deselect: any non-read edge drops the valid flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= (kind == ACC_READ);
  end

  assign drive_en = rd_valid_q && !oe_n && !sleep;
  assign rdata    = drive_en ? rword_q : '0;
endmodule

// File: rtl/sync_bw_sram_chk.sv
module sync_bw_sram_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sel,
  input logic        glob_wr_n,
  input logic        wr_en_n,
  input logic        oe_n,
  input logic        sleep,
  input logic        wake_ok,
  input logic [31:0] rdata,
  input logic        drive_en
);
  a_r6_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !drive_en);
  a_r6_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> (rdata == 32'h0));
  a_r7_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && (!glob_wr_n || !wr_en_n)) |=> !drive_en);
  a_r8_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !drive_en);
  a_r9_sleep_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !drive_en);
  a_r4_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wake_ok && glob_wr_n && wr_en_n) |=> (drive_en || oe_n || sleep));
  a_r10_waking_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_ok |=> !drive_en);
endmodule

bind sync_bw_sram sync_bw_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .glob_wr_n(glob_wr_n),
  .wr_en_n(wr_en_n), .oe_n(oe_n), .sleep(sleep), .wake_ok(wake_ok),
  .rdata(rdata), .drive_en(drive_en)
);

// File: tb/sync_bw_sram_test.sv
`timescale 1ns/1ps
module sync_bw_sram_test;
  localparam int AW    = 4;
  localparam int WAKE  = 3;
  localparam int DEPTH = 1 << AW;
  localparam int NVEC  = 14;

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, gw_n = 1'b1, we_n = 1'b1;
  logic oe_n = 1'b0, sleep = 1'b0;
  logic [3:0]    bs_n  = 4'hF;
  logic [AW-1:0] addr  = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          drive_en;
  logic [31:0]   model [DEPTH];
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sync_bw_sram #(.ADDR_W(AW), .WAKE_CYCLES(WAKE)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .glob_wr_n(gw_n),
    .wr_en_n(we_n), .byte_sel_n(bs_n), .wdata(wdata), .oe_n(oe_n),
    .sleep(sleep), .rdata(rdata), .drive_en(drive_en)
  );

  // {sel, glob_wr_n, wr_en_n, byte_sel_n, addr, wdata, expected drive}
  localparam logic [43:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 1'b1, 4'hF, 4'd3, 32'h0,        1'b1}, // R4 read
    {1'b1, 1'b1, 1'b0, 4'hE, 4'd3, 32'h11223344, 1'b0}, // R2 lane 0 only
    {1'b1, 1'b1, 1'b1, 4'hF, 4'd3, 32'h0,        1'b1}, // R5 read after write
    {1'b1, 1'b1, 1'b0, 4'hF, 4'd5, 32'hFFFFFFFF, 1'b0}, // R3 no lane
    {1'b1, 1'b1, 1'b1, 4'hF, 4'd5, 32'h0,        1'b1},
    {1'b1, 1'b0, 1'b1, 4'hF, 4'd6, 32'h12345678, 1'b0}, // R1 global
    {1'b1, 1'b1, 1'b1, 4'hF, 4'd6, 32'h0,        1'b1},
    {1'b1, 1'b1, 1'b0, 4'h5, 4'd6, 32'hAABBCCDD, 1'b0}, // R2 lanes 1 and 3
    {1'b1, 1'b1, 1'b1, 4'hF, 4'd6, 32'h0,        1'b1},
    {1'b0, 1'b1, 1'b1, 4'hF, 4'd0, 32'h0,        1'b0}, // R8 deselect
    {1'b1, 1'b1, 1'b1, 4'hF, 4'd0, 32'h0,        1'b1},
    {1'b1, 1'b0, 1'b0, 4'h0, 4'd7, 32'h0BADF00D, 1'b0}, // R1 global over lanes
    {1'b1, 1'b1, 1'b1, 4'hF, 4'd7, 32'h0,        1'b1},
    {1'b1, 1'b1, 1'b1, 4'hF, 4'd6, 32'h0,        1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mdl(input logic s, g, w, input logic [3:0] b,
                     input logic [AW-1:0] a, input logic [31:0] d);
    if (s && (!g || !w)) begin
      for (int k = 0; k < 4; k++)
        if (!g || !b[k]) model[a][8*k +: 8] = d[8*k +: 8];
    end
  endtask

  task automatic step(input logic s, g, w, input logic [3:0] b,
                      input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = s; gw_n = g; we_n = w; bs_n = b; addr = a; wdata = d;
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R11 reset drive", {31'h0, drive_en}, 32'h0);
    chk("R11 reset data", rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // fill every word with global writes
    for (int i = 0; i < DEPTH; i++) begin
      mdl(1'b1, 1'b0, 1'b1, 4'hF, AW'(i), 32'hA5000000 | i);
      step(1'b1, 1'b0, 1'b1, 4'hF, AW'(i), 32'hA5000000 | i);
      chk("R7 write keeps drive low", {31'h0, drive_en}, 32'h0);
    end

    for (int i = 0; i < NVEC; i++) begin
      logic s, g, w, ed;
      logic [3:0] b;
      logic [AW-1:0] a;
      logic [31:0] d;
      {s, g, w, b, a, d, ed} = VEC[i];
      mdl(s, g, w, b, a, d);
      step(s, g, w, b, a, d);
      chk($sformatf("R4 table drive vec%0d", i), {31'h0, drive_en}, {31'h0, ed});
      if (ed) chk($sformatf("R4 table data vec%0d", i), rdata, model[a]);
    end

    // R6: output enable without a clock
    step(1'b1, 1'b1, 1'b1, 4'hF, 4'd3, 32'h0);
    chk("R6 driving before oe", rdata, model[3]);
    #1 oe_n = 1'b1;
    #1 chk("R6 oe high drive", {31'h0, drive_en}, 32'h0);
    chk("R6 oe high data zero", rdata, 32'h0);
    oe_n = 1'b0;
    #1 chk("R6 oe low again", rdata, model[3]);

    // R9: sleep drops drive at once, commands ignored
    step(1'b1, 1'b1, 1'b1, 4'hF, 4'd4, 32'h0);
    chk("R9 read before sleep", rdata, model[4]);
    #1 sleep = 1'b1;
    #1 chk("R9 sleep drive", {31'h0, drive_en}, 32'h0);
    for (int i = 0; i < 2; i++) begin
      step(1'b1, 1'b0, 1'b1, 4'hF, 4'd1, 32'hDEAD0001);
      chk("R9 asleep drive", {31'h0, drive_en}, 32'h0);
    end
    step(1'b1, 1'b1, 1'b1, 4'hF, 4'd1, 32'h0);
    chk("R9 asleep read ignored", {31'h0, drive_en}, 32'h0);
    sleep = 1'b0;

    // R10: recovery edges ignore commands
    for (int i = 0; i < WAKE; i++) begin
      step(1'b1, 1'b0, 1'b1, 4'hF, 4'd2, 32'hDEAD0002);
      chk("R10 waking drive", {31'h0, drive_en}, 32'h0);
    end
    step(1'b0, 1'b1, 1'b1, 4'hF, 4'd0, 32'h0);
    chk("R10 idle after wake", {31'h0, drive_en}, 32'h0);
    step(1'b1, 1'b1, 1'b1, 4'hF, 4'd1, 32'h0);
    chk("R9 contents kept", rdata, model[1]);
    step(1'b1, 1'b1, 1'b1, 4'hF, 4'd2, 32'h0);
    chk("R10 recovery write ignored", rdata, model[2]);
    mdl(1'b1, 1'b0, 1'b1, 4'hF, 4'd2, 32'hC0FFEE00);
    step(1'b1, 1'b0, 1'b1, 4'hF, 4'd2, 32'hC0FFEE00);
    step(1'b1, 1'b1, 1'b1, 4'hF, 4'd2, 32'h0);
    chk("R5 write accepted after wake", rdata, model[2]);

    finish_run();
  end
endmodule